// File: doc/BRIEF.md
# Parallel-Prefix Binary Adder

This block adds two unsigned words of a power-of-two width together with a single carry-in bit. It returns the wrapped sum and the carry out of the top position. It is purely combinational. Instead of passing a carry from bit to bit, it builds the carries with a tree of group generate/propagate terms. The span of each group doubles from one level to the next, so the logic depth grows with log2 of the width instead of with the width.

Each bit position has a small cell that forms its own generate (both operand bits set) and propagate (operand bits differ). The carry-in enters as an extra lowest position whose generate is the carry-in and whose propagate is zero. Merge levels with spans 1, 2, 4 and so on then give, at every position, the carry that reaches it. A final stage XORs each bit propagate with its incoming carry to form the sum. The carry into the position just above the top bit becomes the carry-out.

Top module: `prefix_adder`

## Requirements
- R1: `sum` equals (`a` + `b` + `cin`) modulo 2^WIDTH for every input combination, with `a` and `b` read as unsigned integers.
- R2: `cout` equals bit WIDTH of the unsigned value `a` + `b` + `cin`.
- R3: With `a` = 0, `b` = 0 and `cin` = 0, `sum` is 0 and `cout` is 0.
- R4: When `b` is the bitwise complement of `a` and `cin` = 1, the carry passes through every position: `sum` is 0 and `cout` is 1.
- R5: When `b` is the bitwise complement of `a` and `cin` = 0, no carry arises: `sum` has every bit set and `cout` is 0.
- R6: Swapping `a` and `b` leaves `sum` and `cout` unchanged.
- R7: For fixed operands, the result {`cout`,`sum`} with `cin` = 1 is exactly one greater than the result with `cin` = 0.
- R8: When bit WIDTH-1 of both `a` and `b` is 1, `cout` is 1 whatever the other inputs are.
- R9: When bit WIDTH-1 of both `a` and `b` is 0, `cout` is 0 whatever the other inputs are.
- R10: After the last merge level, no position still reports group propagate, because every group span reaches the carry-in position, which never propagates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand, unsigned |
| b | input | WIDTH | Second operand, unsigned |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum modulo 2^WIDTH |
| cout | output | 1 | Carry out of bit WIDTH-1 |

## Verification
Both outputs are combinational, so every result is due in the same clock cycle as its stimulus, with zero register stages on the way. The bench applies operands shortly after a rising edge and reads `sum` and `cout` at the following falling edge. By then the result has settled and the next stimulus has not yet been applied. Each expected value comes from a behavioural queue model that is loaded when the stimulus is driven and drained at that falling edge. A 4-bit copy is covered exhaustively, and the 32-bit default gets directed corner patterns plus a randomized sweep.

// File: rtl/prefix_adder_pkg.sv
// Package: shared generate/propagate pair type and the merge operator
// used by every prefix level. Assumes nothing about width.
package prefix_adder_pkg;

    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    // Combine an upper group with the adjacent lower group below it.
    function automatic gp_t gp_merge(input gp_t upper, input gp_t lower);
        gp_t r;
        r.g = upper.g | (upper.p & lower.g);
        r.p = upper.p & lower.p;
        return r;
    endfunction

endpackage

// File: rtl/prefix_bit_cell.sv
// Module: prefix_bit_cell
// Forms the single-bit generate and propagate terms of one position.
// Assumes the propagate is the XOR form, so it doubles as the half sum.
module prefix_bit_cell
    import prefix_adder_pkg::*;
(
    input  logic op_x,
    input  logic op_y,
    output gp_t  bit_gp
);

    // Purpose: bit-level generate and propagate.
    always_comb begin
        bit_gp.g = op_x & op_y;
        bit_gp.p = op_x ^ op_y;
    end

endmodule

// File: rtl/prefix_merge_level.sv
// Module: prefix_merge_level
// One level of the doubling-span tree. Each position at or above SPAN
// merges with the group SPAN places below it. Positions below SPAN
// already cover the whole range down to the carry-in slot and pass
// through unchanged.
// Assumes NPOS positions with the carry-in at index 0.
module prefix_merge_level
    import prefix_adder_pkg::*;
#(
    parameter int NPOS = 33,
    parameter int SPAN = 1
) (
    input  gp_t [NPOS-1:0] grp_in,
    output gp_t [NPOS-1:0] grp_out
);

    for (genvar x = 0; x < NPOS; x++) begin : g_pos
        if (x >= SPAN) begin : g_merge
            // Purpose: widen the group at x by the group directly below it.
            assign grp_out[x] = gp_merge(grp_in[x], grp_in[x-SPAN]);
        end else begin : g_pass
            // Purpose: span already reaches index 0; keep as is.
            assign grp_out[x] = grp_in[x];
        end
    end

endmodule

// File: rtl/prefix_sum_stage.sv
// Module: prefix_sum_stage
// Makes each sum bit from its bit propagate and its incoming carry.
// Assumes carry[i] is the resolved carry into bit i.
module prefix_sum_stage #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] half_sum,
    input  logic [WIDTH-1:0] carry,
    output logic [WIDTH-1:0] sum
);

    // Purpose: final XOR per bit.
    always_comb sum = half_sum ^ carry;

endmodule

// File: rtl/prefix_adder.sv
// Module: prefix_adder
// Combinational WIDTH-bit adder whose carries come from a logarithmic
// prefix tree of group generate/propagate terms. Index 0 of the tree
// holds the carry-in (generate = cin, propagate = 0). Index i+1 holds
// operand bit i.
// Assumes WIDTH is a power of two, at least 2.
module prefix_adder
    import prefix_adder_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);

    localparam int NPOS   = WIDTH + 1;
    localparam int LEVELS = $clog2(NPOS);

    gp_t  [WIDTH-1:0] bit_gp;
    gp_t  [NPOS-1:0]  tree [0:LEVELS];
    logic [WIDTH-1:0] half_sum;
    logic [WIDTH-1:0] carry;
    logic [NPOS-1:0]  final_p;

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        prefix_bit_cell u_cell (
            .op_x   (a[i]),
            .op_y   (b[i]),
            .bit_gp (bit_gp[i])
        );
    end

    // Purpose: seed the tree with the bit terms above the carry-in slot.
    assign tree[0] = {bit_gp, gp_t'{g: cin, p: 1'b0}};

    for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
        prefix_merge_level #(
            .NPOS (NPOS),
            .SPAN (1 << lv)
        ) u_level (
            .grp_in  (tree[lv]),
            .grp_out (tree[lv+1])
        );
    end

    for (genvar i = 0; i < NPOS; i++) begin : g_tap
        // Purpose: expose the final group propagate of each position.
        assign final_p[i] = tree[LEVELS][i].p;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_carry
        // Purpose: carry into bit i and its half sum.
        assign carry[i]    = tree[LEVELS][i].g;
        assign half_sum[i] = bit_gp[i].p;
    end

    // Purpose: carry out of the top bit.
    assign cout = tree[LEVELS][WIDTH].g;

    prefix_sum_stage #(
        .WIDTH (WIDTH)
    ) u_sum (
        .half_sum (half_sum),
        .carry    (carry),
        .sum      (sum)
    );

endmodule

// File: rtl/prefix_adder_chk.sv
// Module: prefix_adder_chk
// Assertion checker bound to every prefix_adder instance. It compares
// the ports against arithmetic and checks the tree's final propagates.
module prefix_adder_chk #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic             cin,
    input logic [WIDTH-1:0] sum,
    input logic             cout,
    input logic [WIDTH:0]   final_p
);

    logic [WIDTH:0] arith;

    // Purpose: arithmetic value of the addition, for comparison.
    always_comb begin
        arith = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
        AST_SUM_VALUE: assert (sum == arith[WIDTH-1:0]);                      // R1
        AST_CARRY_VALUE: assert (cout == arith[WIDTH]);                       // R2
        AST_ZERO_IN: assert (!(a == '0 && b == '0 && !cin) || (sum == '0 && !cout)); // R3
        AST_FULL_RIPPLE: assert (!(b == ~a && cin) || (sum == '0 && cout));   // R4
        AST_NO_RIPPLE: assert (!(b == ~a && !cin) || (sum == '1 && !cout));   // R5
        AST_TOP_GEN: assert (!(a[WIDTH-1] && b[WIDTH-1]) || cout);            // R8
        AST_TOP_KILL: assert ((a[WIDTH-1] || b[WIDTH-1]) || !cout);           // R9
        AST_PROP_CLEARED: assert (final_p == '0);                             // R10
    end

endmodule

bind prefix_adder prefix_adder_chk #(
    .WIDTH (WIDTH)
) u_chk (
    .a       (a),
    .b       (b),
    .cin     (cin),
    .sum     (sum),
    .cout    (cout),
    .final_p (final_p)
);

// File: tb/prefix_adder_test.sv
// Bench: drives a 32-bit and a 4-bit adder. A behavioural queue model
// supplies the expected results, which are compared once per clock.
module prefix_adder_test;

    localparam int W  = 32;
    localparam int WS = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [W-1:0]  a, b, sum;
    logic          cin, cout;
    logic [WS-1:0] sa, sb, ssum;
    logic          scin, scout;

    int checks = 0;
    int errors = 0;

    longint unsigned exp_q[$];
    longint unsigned sexp_q[$];
    string           tag_q[$];

    prefix_adder #(.WIDTH(W)) uut (
        .a (a), .b (b), .cin (cin), .sum (sum), .cout (cout)
    );

    prefix_adder #(.WIDTH(WS)) uut_w4 (
        .a (sa), .b (sb), .cin (scin), .sum (ssum), .cout (scout)
    );

    task automatic compare(input string tag, input longint unsigned got,
                           input longint unsigned exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // Drive both adders just after a rising edge, queue the model results,
    // then sample at the falling edge of the same cycle.
    task automatic apply(input string tag, input logic [W-1:0] va,
                         input logic [W-1:0] vb, input logic vc,
                         input logic [WS-1:0] wa, input logic [WS-1:0] wb,
                         input logic wc);
        @(posedge clk);
        #1;
        a = va; b = vb; cin = vc;
        sa = wa; sb = wb; scin = wc;
        exp_q.push_back(longint'(va) + longint'(vb) + longint'(vc));
        sexp_q.push_back(longint'(wa) + longint'(wb) + longint'(wc));
        tag_q.push_back(tag);
        @(negedge clk);
        begin
            string t;
            t = tag_q.pop_front();
            compare(t, {cout, sum}, exp_q.pop_front());
            compare({t, " w4"}, {scout, ssum}, sexp_q.pop_front());
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [W-1:0] ra, rb;
        longint unsigned r0, r1;
        a = '0; b = '0; cin = 1'b0;
        sa = '0; sb = '0; scin = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R3: zero inputs give zero outputs (checked during reset).
        compare("R3 zero", {cout, sum}, 0);
        compare("R3 zero w4", {scout, ssum}, 0);
        rst_n = 1'b1;

        // R4: complementary operands with carry-in ripple end to end.
        apply("R4 full ripple", 32'h0F0F_3355, ~32'h0F0F_3355, 1'b1, 4'h5, 4'hA, 1'b1);
        compare("R4 sum zero", sum, 0);
        compare("R4 cout set", cout, 1);
        // R5: complementary operands without carry-in stay all ones.
        apply("R5 no ripple", 32'h1234_5678, ~32'h1234_5678, 1'b0, 4'h3, 4'hC, 1'b0);
        compare("R5 sum ones", sum, 64'hFFFF_FFFF);
        compare("R5 cout clear", cout, 0);
        // R8: both top bits set force the carry-out.
        apply("R8 top gen", 32'h8000_0000, 32'h8000_0000, 1'b0, 4'h8, 4'h8, 1'b0);
        compare("R8 cout", cout, 1);
        // R9: both top bits clear kill the carry-out.
        apply("R9 top kill", 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1, 4'h7, 4'h7, 1'b1);
        compare("R9 cout", cout, 0);
        // R2: max plus max plus one.
        apply("R2 max", '1, '1, 1'b1, 4'hF, 4'hF, 1'b1);

        // R1 R2: exhaustive 4-bit sweep, with the 32-bit copy on sign-extended values.
        for (int i = 0; i < 512; i++) begin
            logic [WS-1:0] xa, xb;
            xa = i[3:0];
            xb = i[7:4];
            apply("R1 R2 exhaustive", {{28{xa[3]}}, xa}, {{28{xb[3]}}, xb}, i[8],
                  xa, xb, i[8]);
        end

        // R1 R6 R7: random operands, swapped order, and both carry-in values.
        for (int n = 0; n < 1500; n++) begin
            ra = $urandom;
            rb = $urandom;
            apply("R1 random", ra, rb, 1'b0, ra[3:0], rb[3:0], 1'b0);
            r0 = {cout, sum};
            apply("R6 swapped", rb, ra, 1'b0, rb[3:0], ra[3:0], 1'b0);
            compare("R6 commute", {cout, sum}, r0);
            apply("R7 cin", ra, rb, 1'b1, ra[3:0], rb[3:0], 1'b1);
            r1 = {cout, sum};
            compare("R7 plus one", r1, r0 + 1);
        end

        // R10 is held by the bound checker for every stimulus above.
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule